// File: doc/BRIEF.md
# Four-Level Boost Mode Selector

This block sequences the two series switches of a single-phase boost rectifier whose output capacitor is an unequal (one third / two thirds) divider. Two comparator flags report whether the rectified input is above one third and above two thirds of the bus voltage. A startup flag marks the power-up interval. From these flags and one PWM waveform from an outer current loop, the block picks one of four operating modes. In each mode it steers the PWM onto the two gate outputs in its own way. The aim is that the switching node never swings by more than one third of the bus.

On every mode change the block sends a one-cycle pulse to the current-loop compensator. The pulse tells it to force its stored duty terms to zero or to full scale, according to the direction of the change. The block also produces one strobe per conduction window for two sample-and-hold circuits. The first samples the upper capacitor while the second transistor conducts. The second samples the lower capacitor and the bus while the second diode conducts. Mode changes happen only on a rising PWM edge, which starts a switching period. The new mode is taken only after the comparators have shown the same state at two consecutive period starts.

Top module: `boost4_mode_ctrl`

## Requirements
- R1: After reset, and until the first rising edge of `pwm_i`, `mode_o` is 0 (startup), both gates are low, and no preload pulse or strobe is produced.
- R2: In startup mode (`mode_o`=0) both gates copy `pwm_i` with one clock of latency. The block enters startup mode when the synchronized `start_i` is high, and it does so with the same two-period qualification as any other change.
- R3: In the low mode (`mode_o`=1, input below one third) `gate_sw1_o` is held high and `gate_sw2_o` copies `pwm_i` one clock late.
- R4: In the middle mode (`mode_o`=2) `gate_sw1_o` follows the PWM high portion and `gate_sw2_o` follows its low portion. After every PWM transition both gates stay low for `dead_cycles_i` clocks, so they are never high together.
- R5: In the high mode (`mode_o`=3, input above two thirds) `gate_sw1_o` is held low and `gate_sw2_o` copies `pwm_i` one clock late.
- R6: A candidate mode is taken from the synchronized flags in this priority: start high gives 0, else above-two-thirds gives 3, else above-third gives 2, else 1. The candidate is sampled at each rising PWM edge. The mode changes only when the same candidate differs from the current mode at two consecutive rising edges, so a one-period excursion of the flags is ignored.
- R7: `mode_o` and the gate mapping change only in the cycle that follows a rising edge of `pwm_i`, never inside a switching period.
- R8: Each mode change produces a single-cycle `preload_req_o` pulse, aligned with the new `mode_o` value. In that cycle `preload_full_o` is 0 when the new mode code is higher than the old one and 1 when it is lower.
- R9: `strobe_top_o` pulses once, `SMP_DLY` clocks after `gate_sw2_o` rises, provided the gate has stayed high for all of those clocks. A shorter on-time produces no pulse.
- R10: `strobe_bot_o` pulses once, `SMP_DLY` clocks into each window in which the second diode conducts. In the middle mode that window is `gate_sw1_o` high with `gate_sw2_o` low. In the other modes it is `gate_sw2_o` low after the first PWM edge.
- R11: With `dead_cycles_i` = 0 the middle-mode gates are exact complements with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Power-up flag, asynchronous |
| above_third_i | input | 1 | Comparator: input above one third of bus, asynchronous |
| above_twothird_i | input | 1 | Comparator: input above two thirds of bus, asynchronous |
| pwm_i | input | 1 | PWM from the current loop, synchronous to clk; rising edge starts a period |
| dead_cycles_i | input | DT_W | Middle-mode dead time in clocks |
| gate_sw1_o | output | 1 | Gate of the first (upper) switch |
| gate_sw2_o | output | 1 | Gate of the second (lower) switch |
| mode_o | output | 2 | Current mode: 0 startup, 1 low, 2 middle, 3 high |
| preload_req_o | output | 1 | One-cycle compensator preload request |
| preload_full_o | output | 1 | Preload value: 0 zero, 1 full scale |
| strobe_top_o | output | 1 | Sample strobe for the upper capacitor |
| strobe_bot_o | output | 1 | Sample strobe for the lower capacitor and bus |

## Verification
A mode register that holds the wrong value appears at the gates in the very next cycle. The first switch is stuck high or low, or it copies the PWM, when it should not. It also appears on `mode_o` at once. A broken qualification path shows as a mode change one period too early or too late, together with a preload pulse that is missing or out of place. A dead-time counter that is off by one moves the first middle-mode gate edge by one clock, and the sample strobes move with it. The directed periods therefore compare every gate sample across whole periods, including the periods in which the mode changes.

// File: rtl/b4m_pkg.sv
`timescale 1ns/1ps
package b4m_pkg;
  typedef enum logic [1:0] {
    MODE_START = 2'd0,
    MODE_LOW   = 2'd1,
    MODE_MID   = 2'd2,
    MODE_HIGH  = 2'd3
  } b4m_mode_e;
endpackage

// File: rtl/b4m_sync.sv
`timescale 1ns/1ps
module b4m_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/b4m_mode_fsm.sv
`timescale 1ns/1ps
module b4m_mode_fsm
  import b4m_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_s,
  input  logic      third_s,
  input  logic      twothird_s,
  input  logic      pwm_i,
  output b4m_mode_e mode_q,
  output b4m_mode_e mode_eff,
  output logic      pwm_rise,
  output logic      pwm_edge,
  output logic      preload_req,
  output logic      preload_full
);
  logic      pwm_q;
  logic      change;
  b4m_mode_e cand;
  b4m_mode_e last_cand;

  // candidate priority: startup, then upper threshold, then lower threshold
  always_comb begin
    if (start_s)         cand = MODE_START;
    else if (twothird_s) cand = MODE_HIGH;
    else if (third_s)    cand = MODE_MID;
    else                 cand = MODE_LOW;
  end

  assign pwm_rise = pwm_i & ~pwm_q;
  assign pwm_edge = pwm_i ^ pwm_q;
  // accept only at a period start, and only if seen at the previous start too
  assign change   = pwm_rise && (cand != mode_q) && (cand == last_cand);
  assign mode_eff = change ? cand : mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q        <= 1'b0;
      mode_q       <= MODE_START;
      last_cand    <= MODE_START;
      preload_req  <= 1'b0;
      preload_full <= 1'b0;
    end else begin
      pwm_q       <= pwm_i;
      preload_req <= change;
      if (change) preload_full <= (cand < mode_q);
      if (pwm_rise) last_cand <= cand;
      mode_q <= mode_eff;
    end
  end
endmodule

// File: rtl/b4m_gate_map.sv
`timescale 1ns/1ps
module b4m_gate_map
  import b4m_pkg::*;
#(
  parameter int DT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  b4m_mode_e       mode_eff,
  input  logic            pwm_i,
  input  logic            pwm_rise,
  input  logic            pwm_edge,
  input  logic [DT_W-1:0] dead_i,
  output logic            g1_q,
  output logic            g2_q,
  output logic            armed_q
);
  logic [DT_W-1:0] dt_q, dt_n;
  logic            hold_off;
  logic            live;
  logic            g1_n, g2_n;

  // dead-time: off for dead_i clocks counted from the edge that saw the toggle
  always_comb begin
    dt_n     = dt_q;
    hold_off = 1'b0;
    if (pwm_edge) begin
      hold_off = (dead_i != '0);
      dt_n     = hold_off ? dead_i - 1'b1 : '0;
    end else if (dt_q != '0) begin
      hold_off = 1'b1;
      dt_n     = dt_q - 1'b1;
    end
  end

  assign live = armed_q | pwm_rise;

  always_comb begin
    unique case (mode_eff)
      MODE_START: begin
        g1_n = pwm_i & live;
        g2_n = pwm_i & live;
      end
      MODE_LOW: begin
        g1_n = 1'b1;
        g2_n = pwm_i;
      end
      MODE_MID: begin
        g1_n = ~hold_off & pwm_i;
        g2_n = ~hold_off & ~pwm_i;
      end
      default: begin
        g1_n = 1'b0;
        g2_n = pwm_i;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dt_q    <= '0;
      g1_q    <= 1'b0;
      g2_q    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      dt_q <= dt_n;
      g1_q <= g1_n;
      g2_q <= g2_n;
      if (pwm_rise) armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/b4m_strobe.sv
`timescale 1ns/1ps
module b4m_strobe #(
  parameter int DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic win,
  output logic stb
);
  localparam int          CW   = $clog2(DLY + 1);
  localparam logic [CW-1:0] LAST = CW'(DLY - 1);
  localparam logic [CW-1:0] FULL = CW'(DLY);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      stb <= 1'b0;
    end else if (!win) begin
      cnt <= '0;
      stb <= 1'b0;
    end else begin
      stb <= (cnt == LAST);
      if (cnt != FULL) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/boost4_mode_ctrl.sv
`timescale 1ns/1ps
module boost4_mode_ctrl
  import b4m_pkg::*;
#(
  parameter int DT_W        = 4,
  parameter int SMP_DLY     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            above_third_i,
  input  logic            above_twothird_i,
  input  logic            pwm_i,
  input  logic [DT_W-1:0] dead_cycles_i,
  output logic            gate_sw1_o,
  output logic            gate_sw2_o,
  output logic [1:0]      mode_o,
  output logic            preload_req_o,
  output logic            preload_full_o,
  output logic            strobe_top_o,
  output logic            strobe_bot_o
);
  localparam int NFLAG = 3;
  localparam int NWIN  = 2;

  logic [NFLAG-1:0] flags_s;
  b4m_mode_e        mode_q, mode_eff;
  logic             pwm_rise, pwm_edge, armed;
  logic [NWIN-1:0]  win, stb;

  b4m_sync #(.W(NFLAG), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({start_i, above_twothird_i, above_third_i}),
    .q     (flags_s)
  );

  b4m_mode_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_s      (flags_s[2]),
    .third_s      (flags_s[0]),
    .twothird_s   (flags_s[1]),
    .pwm_i        (pwm_i),
    .mode_q       (mode_q),
    .mode_eff     (mode_eff),
    .pwm_rise     (pwm_rise),
    .pwm_edge     (pwm_edge),
    .preload_req  (preload_req_o),
    .preload_full (preload_full_o)
  );

  b4m_gate_map #(.DT_W(DT_W)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_eff (mode_eff),
    .pwm_i    (pwm_i),
    .pwm_rise (pwm_rise),
    .pwm_edge (pwm_edge),
    .dead_i   (dead_cycles_i),
    .g1_q     (gate_sw1_o),
    .g2_q     (gate_sw2_o),
    .armed_q  (armed)
  );

  // window 0: second transistor on; window 1: second diode conducting
  assign win[0] = armed & gate_sw2_o;
  assign win[1] = armed & ((mode_q == MODE_MID) ? (gate_sw1_o & ~gate_sw2_o)
                                                : ~gate_sw2_o);

  for (genvar w = 0; w < NWIN; w++) begin : g_smp
    b4m_strobe #(.DLY(SMP_DLY)) u_stb (
      .clk   (clk),
      .rst_n (rst_n),
      .win   (win[w]),
      .stb   (stb[w])
    );
  end

  assign strobe_top_o = stb[0];
  assign strobe_bot_o = stb[1];
  assign mode_o       = mode_q;
endmodule

// File: rtl/b4m_checker.sv
`timescale 1ns/1ps
module b4m_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       pwm_i,
  input logic       gate_sw1_o,
  input logic       gate_sw2_o,
  input logic [1:0] mode_o,
  input logic       preload_req_o,
  input logic       preload_full_o,
  input logic       strobe_top_o
);
  a_r2_start_gates_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0) |-> (gate_sw1_o == gate_sw2_o));

  a_r3_low_sw1_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd1) |-> gate_sw1_o);

  a_r4_mid_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2) |-> !(gate_sw1_o && gate_sw2_o));

  a_r5_high_sw1_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd3) |-> !gate_sw1_o);

  a_r7_change_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != $past(mode_o)) |-> ($past(pwm_i) && !$past(pwm_i, 2)));

  a_r8_change_has_preload: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != $past(mode_o)) |-> preload_req_o);

  a_r8_preload_has_change: assert property (@(posedge clk) disable iff (!rst_n)
    preload_req_o |-> (mode_o != $past(mode_o)));

  a_r8_preload_direction: assert property (@(posedge clk) disable iff (!rst_n)
    preload_req_o |-> (preload_full_o == (mode_o < $past(mode_o))));

  a_r8_preload_single: assert property (@(posedge clk) disable iff (!rst_n)
    preload_req_o |=> !preload_req_o);

  a_r9_top_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_top_o |-> $past(gate_sw2_o));
endmodule

bind boost4_mode_ctrl b4m_checker u_b4m_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .pwm_i          (pwm_i),
  .gate_sw1_o     (gate_sw1_o),
  .gate_sw2_o     (gate_sw2_o),
  .mode_o         (mode_o),
  .preload_req_o  (preload_req_o),
  .preload_full_o (preload_full_o),
  .strobe_top_o   (strobe_top_o)
);

// File: tb/test_boost4_mode_ctrl.sv
`timescale 1ns/1ps
module test_boost4_mode_ctrl;
  localparam int DT_W    = 4;
  localparam int SMP_DLY = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            start_i, above_third_i, above_twothird_i, pwm_i;
  logic [DT_W-1:0] dead_cycles_i;
  logic            gate_sw1_o, gate_sw2_o;
  logic [1:0]      mode_o;
  logic            preload_req_o, preload_full_o, strobe_top_o, strobe_bot_o;

  int total = 0;
  int bad   = 0;
  int dead  = 2;

  always #2.5 clk = ~clk;

  boost4_mode_ctrl #(.DT_W(DT_W), .SMP_DLY(SMP_DLY)) i_boost4_mode_ctrl (
    .clk              (clk),
    .rst_n            (rst_n),
    .start_i          (start_i),
    .above_third_i    (above_third_i),
    .above_twothird_i (above_twothird_i),
    .pwm_i            (pwm_i),
    .dead_cycles_i    (dead_cycles_i),
    .gate_sw1_o       (gate_sw1_o),
    .gate_sw2_o       (gate_sw2_o),
    .mode_o           (mode_o),
    .preload_req_o    (preload_req_o),
    .preload_full_o   (preload_full_o),
    .strobe_top_o     (strobe_top_o),
    .strobe_bot_o     (strobe_bot_o)
  );

  task automatic chk(input int act, input int exp, input string tag, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pwm_i = 1'b0;
    end
  endtask

  // one PWM period of P clocks, high for H; sample j follows the edge at which pwm=(j<H)
  task automatic run_check(input int m, input int H, input int P, input bit exp_pre,
                           input bit exp_full, input bit chk_stb, input string tag);
    int s_g1[64], s_g2[64], s_md[64], s_pr[64], s_pf[64], s_st[64], s_sb[64];
    int pt, pb;
    for (int k = 0; k <= P; k++) begin
      @(negedge clk);
      if (k > 0) begin
        s_g1[k-1] = int'(gate_sw1_o);
        s_g2[k-1] = int'(gate_sw2_o);
        s_md[k-1] = int'(mode_o);
        s_pr[k-1] = int'(preload_req_o);
        s_pf[k-1] = int'(preload_full_o);
        s_st[k-1] = int'(strobe_top_o);
        s_sb[k-1] = int'(strobe_bot_o);
      end
      if (k < P) pwm_i = (k < H);
    end
    for (int j = 0; j < P; j++) begin
      int p, e1, e2, t;
      p = (j < H) ? 1 : 0;
      case (m)
        0:       begin e1 = p; e2 = p; end
        1:       begin e1 = 1; e2 = p; end
        3:       begin e1 = 0; e2 = p; end
        default: begin
          t = p ? 0 : H;
          if (j - t < dead) begin e1 = 0; e2 = 0; end
          else begin e1 = p; e2 = 1 - p; end
        end
      endcase
      chk(s_g1[j], e1, tag, $sformatf("gate_sw1 sample %0d", j));
      chk(s_g2[j], e2, tag, $sformatf("gate_sw2 sample %0d", j));
      chk(s_md[j], m, "R7", $sformatf("mode_o sample %0d", j));
      chk(s_pr[j], (j == 0 && exp_pre) ? 1 : 0, "R8", $sformatf("preload_req sample %0d", j));
    end
    if (exp_pre) chk(s_pf[0], int'(exp_full), "R8", "preload_full value");
    if (chk_stb) begin
      if (m == 2) begin
        pt = (P - H - dead >= SMP_DLY) ? H + dead + SMP_DLY : -1;
        pb = (H - dead >= SMP_DLY) ? dead + SMP_DLY : -1;
      end else begin
        pt = (H >= SMP_DLY) ? SMP_DLY : -1;
        pb = (P - H >= SMP_DLY) ? H + SMP_DLY : -1;
      end
      for (int j = 0; j < P; j++) begin
        chk(s_st[j], (j == pt) ? 1 : 0, "R9", $sformatf("strobe_top sample %0d", j));
        chk(s_sb[j], (j == pb) ? 1 : 0, "R10", $sformatf("strobe_bot sample %0d", j));
      end
    end
  endtask

  task automatic t_reset;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(int'(gate_sw1_o), 0, "R1", "gate_sw1 before first pwm");
      chk(int'(gate_sw2_o), 0, "R1", "gate_sw2 before first pwm");
      chk(int'(mode_o), 0, "R1", "mode after reset");
      chk(int'(preload_req_o | strobe_top_o | strobe_bot_o), 0, "R1", "pulses before first pwm");
    end
  endtask

  task automatic t_startup;
    run_check(0, 8, 20, 0, 0, 0, "R2");
    run_check(0, 8, 20, 0, 0, 1, "R2");
  endtask

  task automatic t_enter_low;
    start_i = 1'b0; idle(4);
    run_check(0, 8, 20, 0, 0, 0, "R6");
    run_check(1, 8, 20, 1, 0, 0, "R6");
    run_check(1, 8, 20, 0, 0, 1, "R3");
  endtask

  task automatic t_up_mid;
    above_third_i = 1'b1; idle(4);
    run_check(1, 8, 24, 0, 0, 0, "R6");
    run_check(2, 8, 24, 1, 0, 0, "R4");
    run_check(2, 8, 24, 0, 0, 1, "R4");
  endtask

  task automatic t_glitch;
    above_twothird_i = 1'b1; idle(4);
    run_check(2, 8, 24, 0, 0, 0, "R6");
    above_twothird_i = 1'b0; idle(4);
    run_check(2, 8, 24, 0, 0, 0, "R6");
  endtask

  task automatic t_up_high;
    above_twothird_i = 1'b1; idle(4);
    run_check(2, 8, 24, 0, 0, 0, "R7");
    run_check(3, 8, 20, 1, 0, 0, "R5");
    run_check(3, 8, 20, 0, 0, 1, "R5");
  endtask

  task automatic t_short_on;
    run_check(3, 1, 20, 0, 0, 1, "R9");
  endtask

  task automatic t_down_mid;
    above_twothird_i = 1'b0; idle(4);
    run_check(3, 8, 20, 0, 0, 0, "R6");
    run_check(2, 8, 24, 1, 1, 0, "R8");
  endtask

  task automatic t_dead_zero;
    dead = 0; dead_cycles_i = '0; idle(4);
    run_check(2, 8, 24, 0, 0, 1, "R11");
    dead = 2; dead_cycles_i = DT_W'(2); idle(4);
  endtask

  task automatic t_down_low;
    above_third_i = 1'b0; idle(4);
    run_check(2, 8, 24, 0, 0, 0, "R6");
    run_check(1, 8, 20, 1, 1, 0, "R8");
    run_check(1, 8, 20, 0, 0, 1, "R10");
  endtask

  task automatic t_restart;
    start_i = 1'b1; idle(4);
    run_check(1, 8, 20, 0, 0, 0, "R6");
    run_check(0, 8, 20, 1, 1, 0, "R2");
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b1; above_third_i = 1'b0; above_twothird_i = 1'b0;
    pwm_i = 1'b0; dead_cycles_i = DT_W'(2);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_startup();
    t_enter_low();
    t_up_mid();
    t_glitch();
    t_up_high();
    t_short_on();
    t_down_mid();
    t_dead_zero();
    t_down_low();
    t_restart();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule